// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block is one timer channel that produces a pulse-width-modulated waveform on a single pin. A 16-bit counter counts up from zero, one step per clock in which the count-enable input is high. A period compare register sets the cycle length: when the counter holds that value, the next enabled clock returns it to zero. A duty compare register sets the point in the cycle where the pin switches level. A small control register chooses the level driven at the start of each cycle and the level driven from the duty point onward. If those two choices do not give two distinct fixed levels, the pin is frozen.

The duty register can be double-buffered. With buffering on, software writes go to a shadow register. The shadow value moves into the duty register on the clock that wraps the counter, so a new duty value always starts on a cycle boundary. Two one-clock flags report when the counter has just wrapped and when it has just reached the duty point.

The register write port is a plain single-cycle strobe. It is always accepted and has no back-pressure. A synchronous clear input restarts the cycle.

Top module: `pwm_timer`

## Requirements
- R1: On each clock with `cnt_en` high, the counter advances by one. While `cnt_en` is low the counter holds, and the pin and flags do not change.
- R2: On an enabled clock where the counter equals the period value P, the counter returns to 0. A cycle is therefore P+1 enabled clocks long, and `period_match` is high for exactly the one clock in which the counter holds 0 after that wrap.
- R3: The control register is written with `wr_sel`=2'b10. Bits [1:0] are the start-level code and bits [3:2] are the match-level code. Code 2'b00 means level 0, code 2'b01 means level 1, and codes 2'b1x mean toggle. When the counter takes the duty value D (0 ≤ D ≤ P), the pin switches to the match level and `duty_match` is high for that clock. When the counter wraps to 0 with D ≠ 0, the pin goes to the start level. In steady state the pin is at the match level exactly while the counter is ≥ D.
- R4: With D = 0 the pin stays at the match level for the whole cycle (100%). With D = P+1 no duty match ever occurs and the pin stays at the start level for the whole cycle (0%).
- R5: If either code is a toggle code, or both codes give the same level, the pin holds its present value. The counter and both flags keep running.
- R6: Control bit 4 enables buffering. When it is set, writes with `wr_sel`=2'b01 go to a shadow register. The shadow value is copied into the duty register on the wrap clock, and the first cycle after the wrap already compares against it.
- R7: When buffering is off, a write with `wr_sel`=2'b01 updates the duty register directly. A write with `wr_sel`=2'b00 sets the period. A written value takes part in the compare on the clock after the write.
- R8: `sync_clr` high sets the counter to 0, drives the pin to the start level when the start code is a fixed level, and clears both flags. It takes priority over counting.
- R9: After `rst_n` goes low, the counter is 0, the pin is 0 and both flags are 0. The period register is 0xFFFF, the duty and shadow registers are 0, and the control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 period, 01 duty, 10 control |
| wr_data | input | 16 | Register write data |
| cnt_en | input | 1 | Count enable, one step per high clock |
| sync_clr | input | 1 | Synchronous counter restart |
| pwm_out | output | 1 | PWM pin |
| period_match | output | 1 | One-clock pulse after the counter wraps |
| duty_match | output | 1 | One-clock pulse when the counter reaches the duty value |

## Verification
The pin and both flags are registered, so each one shows the result of an enabled clock edge right after that edge, in the same clock as the new counter value. A register write is seen by the compare on the following edge, and a synchronous clear shows on the outputs one edge after it is applied. The bench drives inputs and samples outputs on falling edges. It therefore reads each result one clock after the edge that caused it. It measures duty by counting pin-high samples and flag pulses over exactly P+1 samples taken after a full warm-up cycle, and it measures distances to flags as numbers of enabled edges.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'b00,
    SEL_DUTY   = 2'b01,
    SEL_CTRL   = 2'b10,
    SEL_NONE   = 2'b11
  } reg_sel_e;

  // bit 4: shadow enable, [3:2]: match-level code, [1:0]: start-level code
  typedef struct packed {
    logic       shadow_en;
    logic [1:0] match_code;
    logic [1:0] start_code;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // a code names a fixed level when its upper bit is clear
  function automatic logic code_is_fixed(input logic [1:0] code);
    return ~code[1];
  endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);

  assign wrap    = (cnt == period);
  assign cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R1: enabled step inside a cycle adds one
  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R1: counter frozen without enable
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt));

  // R2: wrap returns to zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr && wrap) |=> (cnt == '0));

  // R8: clear wins over counting
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wrap_ev,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cmp_duty,
  output ctrl_t            ctrl
);

  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] shadow_q;
  logic             load_shadow;

  assign load_shadow = wrap_ev && ctrl.shadow_en;
  // the compare that starts a new cycle already sees the shadow value
  assign cmp_duty = load_shadow ? shadow_q : duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period   <= '1;
      duty_q   <= '0;
      shadow_q <= '0;
      ctrl     <= '0;
    end else begin
      if (load_shadow) duty_q <= shadow_q;
      if (wr_en) begin
        unique case (reg_sel_e'(wr_sel))
          SEL_PERIOD: period <= wr_data;
          SEL_DUTY: begin
            if (ctrl.shadow_en) shadow_q <= wr_data;
            else                duty_q   <= wr_data;
          end
          SEL_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  // R6: a shadowed duty write leaves the live duty alone unless wrapping
  a_r6_shadow_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.shadow_en && !wrap_ev) |=> $stable(duty_q));

endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_duty,
  input  ctrl_t            ctrl,
  output logic             pwm,
  output logic             period_flag,
  output logic             duty_flag
);

  logic pwm_ok;
  logic hit;
  logic wrap_ev;

  assign pwm_ok = code_is_fixed(ctrl.start_code) && code_is_fixed(ctrl.match_code)
                  && (ctrl.start_code[0] != ctrl.match_code[0]);
  assign hit     = step && (cnt_nxt == cmp_duty);
  assign wrap_ev = step && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm         <= 1'b0;
      period_flag <= 1'b0;
      duty_flag   <= 1'b0;
    end else if (clr) begin
      period_flag <= 1'b0;
      duty_flag   <= 1'b0;
      if (code_is_fixed(ctrl.start_code)) pwm <= ctrl.start_code[0];
    end else begin
      period_flag <= wrap_ev;
      duty_flag   <= hit;
      if (pwm_ok) begin
        if (hit)          pwm <= ctrl.match_code[0];
        else if (wrap_ev) pwm <= ctrl.start_code[0];
      end
    end
  end

  // R5: frozen pin under a disabled level pair
  a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_ok && !clr) |=> $stable(pwm));

  // R1: nothing happens without a step
  a_r1_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step) |=> (!period_flag && !duty_flag));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_en,
  input  logic             sync_clr,
  output logic             pwm_out,
  output logic             period_match,
  output logic             duty_match
);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cmp_duty;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;
  logic             step;
  ctrl_t            ctrl;

  assign step = cnt_en && !sync_clr;

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .clr     (sync_clr),
    .period  (period),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .wrap_ev  (step && wrap),
    .period   (period),
    .cmp_duty (cmp_duty),
    .ctrl     (ctrl)
  );

  pwm_outgen #(.CNT_W(CNT_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (sync_clr),
    .step        (step),
    .wrap        (wrap),
    .cnt_nxt     (cnt_nxt),
    .cmp_duty    (cmp_duty),
    .ctrl        (ctrl),
    .pwm         (pwm_out),
    .period_flag (period_match),
    .duty_flag   (duty_match)
  );

  // R2: the wrap flag only accompanies a zero count
  a_r2_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_match |-> (cnt == '0));

  // R2: with a period above zero the wrap flag is a single pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && period != '0) |=> !period_match);

endmodule

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b11;
  logic [15:0] wr_data = '0;
  logic        cnt_en = 1'b0;
  logic        sync_clr = 1'b0;
  logic        pwm_out, period_match, duty_match;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_en(cnt_en), .sync_clr(sync_clr), .pwm_out(pwm_out),
    .period_match(period_match), .duty_match(duty_match)
  );

  // control words: start code [1:0], match code [3:2], shadow enable bit 4
  localparam logic [15:0] C_S0M1     = 16'h0004;
  localparam logic [15:0] C_S1M0     = 16'h0001;
  localparam logic [15:0] C_SAME     = 16'h0000;
  localparam logic [15:0] C_TOGGLE   = 16'h0008;
  localparam logic [15:0] C_S0M1_BUF = 16'h0014;

  localparam int NV = 10;
  localparam int VP [NV] = '{9, 9, 9, 9, 4, 15, 0, 0, 9, 9};
  localparam int VD [NV] = '{3, 0, 10, 9, 2, 8, 0, 1, 5, 5};
  localparam logic [15:0] VC [NV] = '{C_S0M1, C_S1M0, C_S0M1, C_S0M1, C_S1M0,
                                       C_S0M1, C_S0M1, C_S1M0, C_SAME, C_TOGGLE};
  localparam int VH [NV]  = '{7, 0, 0, 1, 2, 8, 1, 1, 0, 0};
  localparam int VDF [NV] = '{1, 1, 0, 1, 1, 1, 1, 0, 1, 1};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'b11;
  endtask

  task automatic pulse_clr();
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
  endtask

  task automatic measure(input int n, output int hi, output int pm, output int dm);
    hi = 0; pm = 0; dm = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out); pm += int'(period_match); dm += int'(duty_match);
      @(negedge clk);
    end
  endtask

  task automatic edges_to_duty(output int k);
    k = 0;
    while (k < 40) begin
      @(negedge clk);
      k++;
      if (duty_match) break;
    end
  endtask

  initial begin
    int hi, pm, dm, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: state out of reset
    check("R9 pin after reset", int'(pwm_out), 0);
    check("R9 flags after reset", int'(period_match) + int'(duty_match), 0);
    @(negedge clk);
    check("R9 pin idle", int'(pwm_out), 0);

    // table: one cycle measured after a full warm-up cycle (R2 R3 R4 R5)
    for (int v = 0; v < NV; v++) begin
      cnt_en = 1'b0;
      wr(2'b00, 16'(VP[v]));
      wr(2'b01, 16'(VD[v]));
      wr(2'b10, VC[v]);
      cnt_en = 1'b1;
      pulse_clr();
      repeat (VP[v] + 1) @(negedge clk);
      measure(VP[v] + 1, hi, pm, dm);
      check($sformatf("R3/R4/R5 high count vec %0d", v), hi, VH[v]);
      check($sformatf("R2 period flags vec %0d", v), pm, 1);
      check($sformatf("R3 duty flags vec %0d", v), dm, VDF[v]);
    end

    // R1: pause holds everything, resume continues the count
    cnt_en = 1'b0;
    wr(2'b00, 16'd9); wr(2'b01, 16'd5); wr(2'b10, C_S0M1);
    cnt_en = 1'b1;
    pulse_clr();
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    measure(10, hi, pm, dm);
    check("R1 no flags while paused", pm + dm, 0);
    check("R1 pin held while paused", hi, 0);
    cnt_en = 1'b1;
    edges_to_duty(k);
    check("R1 edges from 3 to duty 5", k, 2);

    // R6: shadowed duty lands only at the wrap
    cnt_en = 1'b0;
    wr(2'b10, C_S0M1); wr(2'b01, 16'd2);
    wr(2'b10, C_S0M1_BUF); wr(2'b01, 16'd7);
    cnt_en = 1'b1;
    pulse_clr();
    measure(10, hi, pm, dm);
    check("R6 old duty in current cycle", hi, 8);
    measure(10, hi, pm, dm);
    check("R6 shadow duty after wrap", hi, 3);

    // R7: direct duty write mid-cycle
    cnt_en = 1'b0;
    wr(2'b10, C_S0M1); wr(2'b01, 16'd8);
    cnt_en = 1'b1;
    pulse_clr();
    repeat (2) @(negedge clk);
    cnt_en = 1'b0;
    wr(2'b01, 16'd4);
    cnt_en = 1'b1;
    measure(8, hi, pm, dm);
    check("R7 new duty used next compare", hi, 6);

    // R8: clear mid-cycle returns to start level and restarts
    cnt_en = 1'b0;
    wr(2'b01, 16'd3);
    cnt_en = 1'b1;
    pulse_clr();
    repeat (6) @(negedge clk);
    check("R3 pin at match level past duty", int'(pwm_out), 1);
    pulse_clr();
    check("R8 pin at start level after clear", int'(pwm_out), 0);
    edges_to_duty(k);
    check("R8 edges from clear to duty 3", k, 3);

    // R5: switching to a toggle code freezes a high pin
    pulse_clr();
    repeat (6) @(negedge clk);
    wr(2'b10, C_TOGGLE);
    measure(12, hi, pm, dm);
    check("R5 pin frozen high", hi, 12);
    check("R5 counter keeps running", pm, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule